// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block turns bytes into an asynchronous serial line. A host presents a data byte on a write strobe. The byte is held in a one-entry holding register until the shifter is free. It then leaves as a low start bit, followed by the data bits least significant first, an optional parity bit, and a stop period of one, one-and-a-half or two high bits. A clock-factor divider sets how many input clocks make up one bit.

The framing is set by static configuration inputs: stop code, character length, parity, clock factor and break. A stop code of zero turns the transmitter off. In the five-bit length, a marker of leading ones in the byte shortens the character, so that one to five data bits are sent. Two status outputs tell the host when the holding register can take another byte and when the line has fallen completely quiet.

Top module: `async_char_tx`

## Requirements
- R1: Out of reset, `txd` is 1, `buf_empty` is 1 and `tx_idle` is 1.
- R2: A frame begins with one low bit and sends its data bits least significant first. Every bit lasts N input clocks, where `cfg_div` 00 gives N=1, 01 gives N=16, 10 gives N=32 and 11 gives N=64.
- R3: `cfg_stop` 00 turns transmission off: a held byte stays held, `buf_empty` stays 0 and `txd` stays 1. Code 01 ends each frame with one high stop bit and code 11 ends it with two. A held byte starts once a nonzero code is applied.
- R4: `cfg_stop` 10 ends a frame with one full stop bit followed by a half stop bit of N/2 clocks. With N=1 it gives two full stop bits instead.
- R5: `cfg_len` 00 selects 5 data bits, 01 selects 7, 10 selects 6 and 11 selects 8. In the 6, 7 and 8 bit lengths, byte bits at or above the length are not sent.
- R6: In the 5-bit length, the leading ones in byte bits 7..4 shorten the character, and the data sits in the low bits. Byte pattern 1111000D sends 1 bit, 111000DD sends 2, 11000DDD sends 3, 1000DDDD sends 4 and 000DDDDD sends 5.
- R7: When `cfg_par_en` is 1, a parity bit follows the last data bit and comes before the stops. With `cfg_par_odd` 0 the data plus parity hold an even number of ones, and with 1 they hold an odd number.
- R8: `buf_empty` falls on the cycle after an accepted write. It rises on the clock edge where that byte's start bit begins. A write made while `buf_empty` is 0 is dropped.
- R9: `tx_idle` is 0 from the start bit until the last stop period ends, and 1 afterwards with `txd` at 1. If a byte is waiting when a stop period ends, its start bit follows on the next clock with no idle cycle between the frames.
- R10: While `cfg_brk` is 1, `txd` is 0 and no new frame starts. When `cfg_brk` is released with nothing in flight, `txd` returns to 1 at once, and a waiting byte then starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_stop | input | 2 | Stop code: 00 off, 01 one, 10 one-and-a-half, 11 two |
| cfg_len | input | 2 | Length code: 00 five (marker), 01 seven, 10 six, 11 eight |
| cfg_div | input | 2 | Clock factor: 00 x1, 01 x16, 10 x32, 11 x64 |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_brk | input | 1 | Force the line low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial line, 1 is mark |
| buf_empty | output | 1 | Holding register can take a byte |
| tx_idle | output | 1 | No frame in flight |

## Verification
The main collision is the end of a frame's last stop period falling in the same cycle as the transfer of a waiting byte into the shifter. The bench provokes it by writing a second byte during the first frame's start bit and a third byte one cycle later, while the register is still full. It then compares the line cycle by cycle against both frames joined together. The check fails if `tx_idle` rises between the frames, if the second start bit comes late, or if the dropped third byte ever appears. A similar meeting happens between a break release and a pending byte. There the bench requires the mark level in the release cycle and the start bit one clock later.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

   typedef enum logic [1:0] {
      STOP_OFF      = 2'b00,
      STOP_ONE      = 2'b01,
      STOP_ONE_HALF = 2'b10,
      STOP_TWO      = 2'b11
   } stop_code_e;

   typedef enum logic [1:0] {
      LEN_5 = 2'b00,
      LEN_7 = 2'b01,
      LEN_6 = 2'b10,
      LEN_8 = 2'b11
   } len_code_e;

   typedef enum logic [1:0] {
      DIV_X1  = 2'b00,
      DIV_X16 = 2'b01,
      DIV_X32 = 2'b10,
      DIV_X64 = 2'b11
   } div_code_e;

   // Window of leading marker bits examined in the shortest length.
   localparam int unsigned MARK_W  = 4;
   localparam int unsigned SHORT_W = 5;

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer
   import frame_tx_pkg::*;
#(
   parameter int LOG2_MAX = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] div_i,
   input  logic       restart_i,
   input  logic       half_i,
   input  logic       run_i,
   output logic       end_o
);

   localparam int CW = LOG2_MAX;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] full_m1;
   logic [CW-1:0] half_m1;

   // Reload values: full bit and half bit, minus one.
   always_comb begin
      case (div_i)
         DIV_X16: begin
            full_m1 = CW'((1 << (LOG2_MAX - 2)) - 1);
            half_m1 = CW'((1 << (LOG2_MAX - 3)) - 1);
         end
         DIV_X32: begin
            full_m1 = CW'((1 << (LOG2_MAX - 1)) - 1);
            half_m1 = CW'((1 << (LOG2_MAX - 2)) - 1);
         end
         DIV_X64: begin
            full_m1 = CW'((1 << LOG2_MAX) - 1);
            half_m1 = CW'((1 << (LOG2_MAX - 1)) - 1);
         end
         default: begin
            full_m1 = '0;
            half_m1 = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= half_i ? half_m1 : full_m1;
      end else if (run_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign end_o = run_i && (cnt_q == '0);

   p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !restart_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/tx_char_former.sv
module tx_char_former
   import frame_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FRAME_W    = 12,
   parameter int CNT_W      = 4,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic [DATA_W-1:0]  char_i,
   input  logic [1:0]         len_i,
   input  logic [1:0]         stop_i,
   input  logic               x1_i,
   input  logic               par_en_i,
   input  logic               par_odd_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic [CNT_W-1:0]   nbits_o,
   output logic               half_o
);

   logic [2:0]        lead;
   logic              in_run;
   logic [CNT_W-1:0]  ndata;
   logic [DATA_W-1:0] kept;
   logic              par_on;
   logic              par_bit;

   // Count the ones at the top of the byte, up to the first zero.
   always_comb begin
      lead   = '0;
      in_run = 1'b1;
      for (int i = DATA_W - 1; i >= DATA_W - int'(MARK_W); i--) begin
         if (in_run && char_i[i]) lead = lead + 3'd1;
         else                     in_run = 1'b0;
      end
   end

   always_comb begin
      case (len_i)
         LEN_5:   ndata = CNT_W'(SHORT_W) - CNT_W'(lead);
         LEN_6:   ndata = CNT_W'(6);
         LEN_7:   ndata = CNT_W'(7);
         default: ndata = CNT_W'(DATA_W);
      endcase
   end

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         kept[i] = char_i[i] && (CNT_W'(i) < ndata);
      end
   end

   if (HAS_PARITY) begin : g_parity
      assign par_on = par_en_i;
   end else begin : g_no_parity
      assign par_on = 1'b0;
   end

   assign par_bit = (^kept) ^ par_odd_i;

   // Frame vector, sent LSB first; the upper slots default to mark.
   always_comb begin
      frame_o    = '1;
      frame_o[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (CNT_W'(i) < ndata) frame_o[i+1] = kept[i];
      end
      for (int i = 1; i <= DATA_W; i++) begin
         if (par_on && (ndata == CNT_W'(i))) frame_o[i+1] = par_bit;
      end
   end

   assign nbits_o = CNT_W'(1) + ndata + CNT_W'(par_on)
                  + ((stop_i == STOP_ONE) ? CNT_W'(1) : CNT_W'(2));
   assign half_o  = (stop_i == STOP_ONE_HALF) && !x1_i;

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
   import frame_tx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int LOG2_MAX_DIV = 6,
   parameter bit HAS_PARITY   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_stop,
   input  logic [1:0]        cfg_len,
   input  logic [1:0]        cfg_div,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_brk,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              buf_empty,
   output logic              tx_idle
);

   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (DATA_W != 8) begin : g_bad_width
      $error("async_char_tx: length codes assume an 8-bit character");
   end
   if (LOG2_MAX_DIV < 3) begin : g_bad_div
      $error("async_char_tx: divider too small for a half stop bit");
   end

   logic [DATA_W-1:0]  hold_q;
   logic               hold_full_q;
   logic               busy_q;
   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   left_q;
   logic               half_q;

   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;
   logic               half_last;
   logic               bit_end;
   logic               last_bit;
   logic               adv;
   logic               can_load;
   logic               half_sel;

   tx_char_former #(
      .DATA_W    (DATA_W),
      .FRAME_W   (FRAME_W),
      .CNT_W     (CNT_W),
      .HAS_PARITY(HAS_PARITY)
   ) u_former (
      .char_i   (hold_q),
      .len_i    (cfg_len),
      .stop_i   (cfg_stop),
      .x1_i     (cfg_div == DIV_X1),
      .par_en_i (cfg_par_en),
      .par_odd_i(cfg_par_odd),
      .frame_o  (frame),
      .nbits_o  (nbits),
      .half_o   (half_last)
   );

   assign last_bit = busy_q && bit_end && (left_q == CNT_W'(1));
   assign adv      = busy_q && bit_end && (left_q != CNT_W'(1));
   assign can_load = hold_full_q && (cfg_stop != STOP_OFF) && !cfg_brk
                  && (!busy_q || last_bit);
   assign half_sel = adv && half_q && (left_q == CNT_W'(2));

   tx_bit_timer #(
      .LOG2_MAX(LOG2_MAX_DIV)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_i    (cfg_div),
      .restart_i(can_load || adv),
      .half_i   (half_sel),
      .run_i    (busy_q),
      .end_o    (bit_end)
   );

   // Holding register: filled only while empty.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
      end else if (can_load) begin
         hold_full_q <= 1'b0;
      end else if (wr_en && !hold_full_q) begin
         hold_q      <= wr_data;
         hold_full_q <= 1'b1;
      end
   end

   // Shifter: a waiting byte replaces a finishing frame in the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sh_q   <= '1;
         left_q <= '0;
         half_q <= 1'b0;
      end else if (can_load) begin
         busy_q <= 1'b1;
         sh_q   <= frame;
         left_q <= nbits;
         half_q <= half_last;
      end else if (last_bit) begin
         busy_q <= 1'b0;
         sh_q   <= '1;
      end else if (adv) begin
         sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign txd       = cfg_brk ? 1'b0 : (busy_q ? sh_q[0] : 1'b1);
   assign buf_empty = !hold_full_q;
   assign tx_idle   = !busy_q;

   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (sh_q[0] == 1'b0));

   p_off_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && (cfg_stop == STOP_OFF)) |=> !busy_q);

   p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> ((left_q >= CNT_W'(3)) && (left_q <= CNT_W'(FRAME_W))));

   p_empty_at_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> buf_empty);

   p_hold_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_empty && !can_load) |=> ($stable(hold_q) && !buf_empty));

   p_brk_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_brk && !busy_q) |=> !busy_q);

endmodule

// File: tb/sim_async_char_tx.sv
`timescale 1ns/1ps
module sim_async_char_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_stop = 2'b01;
   logic [1:0] cfg_len = 2'b11;
   logic [1:0] cfg_div = 2'b01;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_brk = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       txd, buf_empty, tx_idle;

   always #4 clk = ~clk;

   async_char_tx u0 (
      .clk(clk), .rst_n(rst_n), .cfg_stop(cfg_stop), .cfg_len(cfg_len),
      .cfg_div(cfg_div), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_brk(cfg_brk), .wr_en(wr_en), .wr_data(wr_data),
      .txd(txd), .buf_empty(buf_empty), .tx_idle(tx_idle)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit exp_line [0:8191];
   int exp_len = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int bit_clocks();
      case (cfg_div)
         2'b00:   return 1;
         2'b01:   return 16;
         2'b10:   return 32;
         default: return 64;
      endcase
   endfunction

   task automatic push(input bit v, input int d);
      for (int c = 0; c < d; c++) begin
         exp_line[exp_len] = v;
         exp_len++;
      end
   endtask

   // Expected line from the requirements (R2..R7).
   task automatic add_frame(input logic [7:0] b);
      int n;
      int nb;
      bit p;
      nb = bit_clocks();
      case (cfg_len)
         2'b00: begin
            if (b[7:4] == 4'hF)        n = 1;
            else if (b[7:5] == 3'b111) n = 2;
            else if (b[7:6] == 2'b11)  n = 3;
            else if (b[7])             n = 4;
            else                       n = 5;
         end
         2'b01:   n = 7;
         2'b10:   n = 6;
         default: n = 8;
      endcase
      push(1'b0, nb);
      p = cfg_par_odd;
      for (int i = 0; i < n; i++) begin
         push(b[i], nb);
         p = p ^ b[i];
      end
      if (cfg_par_en) push(p, nb);
      case (cfg_stop)
         2'b01: push(1'b1, nb);
         2'b10: begin
            push(1'b1, nb);
            if (nb == 1) push(1'b1, 1);
            else         push(1'b1, nb / 2);
         end
         default: begin
            push(1'b1, nb);
            push(1'b1, nb);
         end
      endcase
   endtask

   task automatic put_byte(input logic [7:0] b);
      wr_en   = 1'b1;
      wr_data = b;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // Called at the negedge holding the first start-bit sample.
   task automatic run_expect(input string req);
      int bad_at;
      int bad_val;
      bit idle_seen;
      bad_at = -1;
      bad_val = 0;
      idle_seen = 1'b0;
      for (int i = 0; i < exp_len; i++) begin
         if (i > 0) @(negedge clk);
         if ((txd !== exp_line[i]) && (bad_at < 0)) begin
            bad_at = i;
            bad_val = int'(txd);
         end
         if (tx_idle !== 1'b0) idle_seen = 1'b1;
      end
      chk(bad_at < 0, req, "line mismatch at cycle index (actual = line value)",
          bad_val, (bad_at < 0) ? 0 : int'(exp_line[bad_at]));
      chk(!idle_seen, "R9", "tx_idle seen inside frame", int'(idle_seen), 0);
      @(negedge clk);
      chk(tx_idle === 1'b1 && txd === 1'b1, "R9", "idle and mark after last stop",
          int'({tx_idle, txd}), 3);
      exp_len = 0;
   endtask

   task automatic send_and_check(input logic [7:0] b, input string req);
      exp_len = 0;
      add_frame(b);
      put_byte(b);
      chk(buf_empty === 1'b0 && tx_idle === 1'b1, "R8", "byte held before shifting",
          int'({buf_empty, tx_idle}), 1);
      @(negedge clk);
      chk(buf_empty === 1'b1, "R8", "empty at start bit", int'(buf_empty), 1);
      run_expect(req);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(txd === 1'b1 && buf_empty === 1'b1 && tx_idle === 1'b1, "R1",
          "reset outputs", int'({txd, buf_empty, tx_idle}), 7);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd === 1'b1 && buf_empty === 1'b1 && tx_idle === 1'b1, "R1",
          "outputs after reset", int'({txd, buf_empty, tx_idle}), 7);
   endtask

   task automatic t_rates();
      cfg_par_en = 1'b0; cfg_stop = 2'b01; cfg_len = 2'b11;
      cfg_div = 2'b01; send_and_check(8'hA5, "R2");
      cfg_div = 2'b10; send_and_check(8'h96, "R2");
      cfg_div = 2'b11; send_and_check(8'h3B, "R2");
      cfg_div = 2'b00; cfg_stop = 2'b11; send_and_check(8'h3C, "R3");
      cfg_div = 2'b01; send_and_check(8'hC3, "R3");
   endtask

   task automatic t_lengths();
      cfg_div = 2'b00; cfg_stop = 2'b01; cfg_par_en = 1'b0;
      cfg_len = 2'b10; send_and_check(8'hC5, "R5");
      cfg_len = 2'b01; send_and_check(8'hD9, "R5");
      cfg_len = 2'b10; send_and_check(8'h7E, "R5");
   endtask

   task automatic t_five();
      logic [7:0] pats [5];
      pats[0] = 8'hF1; pats[1] = 8'hE2; pats[2] = 8'hC5;
      pats[3] = 8'h8A; pats[4] = 8'h15;
      cfg_div = 2'b00; cfg_stop = 2'b01; cfg_len = 2'b00; cfg_par_en = 1'b0;
      for (int k = 0; k < 5; k++) send_and_check(pats[k], "R6");
      cfg_div = 2'b01; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
      send_and_check(8'hE3, "R6");
      cfg_par_en = 1'b0;
   endtask

   task automatic t_parity();
      cfg_div = 2'b01; cfg_stop = 2'b01; cfg_len = 2'b11; cfg_par_en = 1'b1;
      cfg_par_odd = 1'b0; send_and_check(8'hB3, "R7");
      cfg_par_odd = 1'b1; send_and_check(8'hB3, "R7");
      cfg_len = 2'b01; send_and_check(8'h41, "R7");
      cfg_par_odd = 1'b0; send_and_check(8'hC1, "R7");
      cfg_par_en = 1'b0; cfg_len = 2'b11;
   endtask

   task automatic t_half();
      cfg_stop = 2'b10; cfg_len = 2'b11; cfg_par_en = 1'b0;
      cfg_div = 2'b01; send_and_check(8'h0F, "R4");
      cfg_div = 2'b10; send_and_check(8'hF0, "R4");
      cfg_div = 2'b00; send_and_check(8'h55, "R4");
      cfg_stop = 2'b01;
   endtask

   // Frame end and a waiting byte meet; a third write is dropped.
   task automatic t_back_to_back();
      bit ok;
      cfg_div = 2'b01; cfg_stop = 2'b01; cfg_len = 2'b11; cfg_par_en = 1'b0;
      exp_len = 0;
      add_frame(8'h6D);
      add_frame(8'h92);
      put_byte(8'h6D);
      @(negedge clk);
      fork
         begin
            put_byte(8'h92);
            put_byte(8'h0F);
         end
         run_expect("R9");
      join
      ok = 1'b1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (txd !== 1'b1 || buf_empty !== 1'b1 || tx_idle !== 1'b1) ok = 1'b0;
      end
      chk(ok, "R8", "write while full never sent", int'(ok), 1);
   endtask

   task automatic t_off();
      bit ok;
      cfg_div = 2'b01; cfg_len = 2'b11; cfg_stop = 2'b00;
      put_byte(8'h5A);
      ok = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (txd !== 1'b1 || buf_empty !== 1'b0 || tx_idle !== 1'b1) ok = 1'b0;
      end
      chk(ok, "R3", "stop code 00 holds byte, line mark", int'(ok), 1);
      cfg_stop = 2'b01;
      exp_len = 0;
      add_frame(8'h5A);
      @(negedge clk);
      run_expect("R3");
   endtask

   task automatic t_break();
      bit ok;
      cfg_div = 2'b01; cfg_len = 2'b11; cfg_stop = 2'b01;
      cfg_brk = 1'b1;
      #1;
      chk(txd === 1'b0, "R10", "break drives line low", int'(txd), 0);
      @(negedge clk);
      put_byte(8'h33);
      ok = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (txd !== 1'b0 || buf_empty !== 1'b0 || tx_idle !== 1'b1) ok = 1'b0;
      end
      chk(ok, "R10", "no frame starts during break", int'(ok), 1);
      cfg_brk = 1'b0;
      #1;
      chk(txd === 1'b1, "R10", "mark on break release", int'(txd), 1);
      exp_len = 0;
      add_frame(8'h33);
      @(negedge clk);
      run_expect("R10");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_rates();
      t_lengths();
      t_five();
      t_parity();
      t_half();
      t_back_to_back();
      t_off();
      t_break();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule